// File: doc/BRIEF.md
# Oversampled serial receiver with framing and line-break detection

This block recovers bytes from an asynchronous serial line that idles high. A strobe at sixteen times the bit rate drives all of its timing. The line input must already be synchronised to the clock. A low sample on a strobe while the receiver is idle opens a frame. The receiver checks the start bit at its midpoint and rejects a short glitch. It then takes eight data bits, least significant first, and an optional parity bit. Last, it takes the stop bit. At the end of each frame it raises a one-cycle status pulse for a bad stop bit or a parity mismatch. A good frame delivers its byte instead.

Good bytes leave on a valid/ready port that holds one byte. The line cannot be paused, so there is no back-pressure toward the line. A byte waits, unchanged, with `rx_valid` high until the consumer takes it with `rx_ready`. If a newer good byte arrives first, it replaces the waiting one. A separate counter measures continuous low time on the line in whole character times. When that time reaches the selected level, it raises a single break pulse and holds a break-active flag. The flag clears when the line is seen high again.

Top module: `uart_rx_core`

## Requirements
- R1: While idle and enabled, a low `rx_in` sample on an `os_tick` starts a frame, and that tick is tick 0. The start bit is checked on tick 8. If it is high there, the receiver returns to idle with no pulse and no byte.
- R2: Data bit i (i = 0..7) is sampled on tick 8+16*(i+1) and placed at bit position i of the byte. The least significant bit arrives first.
- R3: A frame whose stop bit samples high, with no parity mismatch, raises `rx_valid` with the byte on `rx_data`. This happens two clock cycles after the clock edge that sampled the stop bit.
- R4: With `par_en`=1 a parity bit follows the data. `par_odd`=0 expects an even count of ones over data plus parity, and `par_odd`=1 an odd count. A mismatch gives a one-cycle `parity_err` pulse and no byte.
- R5: A stop bit that samples low gives a one-cycle `frame_err` pulse and no byte. All status pulses appear one cycle after the edge that sampled the stop bit.
- R6: With parity enabled and even, ten low bit times followed by a high stop bit deliver byte 0x00 with no error. With parity disabled, the same line gives a `frame_err`.
- R7: The break threshold is (2 << `brk_lvl`) character times, where a character is 160 ticks, or 176 ticks with parity. When continuous low samples reach that count, `break_err` pulses for one cycle and `break_active` rises.
- R8: During one continuous low period `break_err` fires only once. `frame_err` keeps pulsing at every character time, before and after the break.
- R9: `break_active` clears on the first tick that samples `rx_in` high. A later low period that reaches the threshold fires `break_err` again.
- R10: `rx_valid` with `rx_ready` low keeps `rx_data` stable. `rx_valid` with `rx_ready` high drops `rx_valid` on the next edge. A new good byte loads and keeps `rx_valid` high even in a cycle where `rx_ready` is high.
- R11: `rx_en`=0 aborts any frame, clears the low-time counter and `break_active`, and suppresses all pulses.
- R12: After reset, `rx_valid`, all pulses and `break_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| rx_in | input | 1 | synchronised serial line |
| os_tick | input | 1 | one-cycle strobe at 16x bit rate |
| rx_en | input | 1 | receiver enable |
| par_en | input | 1 | parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| brk_lvl | input | 2 | break level: 2,4,8,16 characters |
| rx_data | output | 8 | received byte |
| rx_valid | output | 1 | byte available |
| rx_ready | input | 1 | consumer takes byte |
| frame_err | output | 1 | stop bit low pulse |
| parity_err | output | 1 | parity mismatch pulse |
| break_err | output | 1 | break reached pulse |
| break_active | output | 1 | break in progress |

## Verification
The loading of a fresh byte and the consumer's acceptance of the previous one can fall on the same clock edge. Likewise, a `frame_err` pulse can land close to the `break_err` pulse while the line is held low. The bench drives `rx_ready` from a pseudo-random sequence during back-to-back frames, so loads land in cycles where `rx_ready` is high. It also holds the line low long enough for several framing errors to surround the break threshold. A behavioural reference model predicts every output on every clock and judges each collision, expecting the load to win and both pulses to appear independently.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_PAR,
    RXS_STOP
  } rxs_e;

  function automatic logic [4:0] brk_chars(input logic [1:0] lvl);
    return 5'd2 << lvl;
  endfunction
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rx,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          good_o,
  output logic [DW-1:0] byte_o,
  output logic          ferr_o,
  output logic          perr_o
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DW + 1);
  localparam int MID = OSR / 2;

  rxs_e          state;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          par_bad;
  logic          last_os;
  logic          mid_pt;

  assign last_os = (tcnt == CW'(OSR - 1));
  assign mid_pt  = (tcnt == CW'(MID - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RXS_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bad <= 1'b0;
      good_o  <= 1'b0;
      ferr_o  <= 1'b0;
      perr_o  <= 1'b0;
      byte_o  <= '0;
    end else begin
      good_o <= 1'b0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
      if (!en) begin
        state <= RXS_IDLE;
        tcnt  <= '0;
      end else if (tick) begin
        unique case (state)
          RXS_IDLE: begin
            if (!rx) begin
              state   <= RXS_START;
              tcnt    <= '0;
              par_bad <= 1'b0;
            end
          end
          RXS_START: begin
            if (mid_pt) begin
              tcnt <= '0;
              bidx <= '0;
              state <= rx ? RXS_IDLE : RXS_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RXS_DATA: begin
            if (last_os) begin
              tcnt  <= '0;
              shreg <= {rx, shreg[DW-1:1]};
              if (bidx == BW'(DW - 1)) state <= par_en ? RXS_PAR : RXS_STOP;
              else bidx <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RXS_PAR: begin
            if (last_os) begin
              tcnt    <= '0;
              par_bad <= ((^shreg) ^ rx) != par_odd;
              state   <= RXS_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RXS_STOP: begin
            if (last_os) begin
              tcnt   <= '0;
              ferr_o <= !rx;
              perr_o <= par_en && par_bad;
              good_o <= rx && !(par_en && par_bad);
              byte_o <= shreg;
              state  <= RXS_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= RXS_IDLE;
        endcase
      end
    end
  end

  // R5: a byte and a framing error never come from the same frame
  a_r5_good_excl_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    !(good_o && ferr_o));
  // R4: a parity error needs parity enabled at the sampling edge
  a_r4_perr_needs_par: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(par_en));
  // R11: frame results only follow an enabled tick
  a_r11_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (good_o || ferr_o || perr_o) |-> ($past(tick) && $past(en)));
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rx,
  input  logic       par_en,
  input  logic [1:0] lvl,
  output logic       brk_o,
  output logic       active_o
);
  localparam int CHAR_NP = OSR * (DW + 2);
  localparam int CHAR_P  = OSR * (DW + 3);
  localparam int MAXLVL  = 16;
  localparam int CNTW    = $clog2(MAXLVL * CHAR_P + 1);

  logic [CNTW-1:0] low_cnt;
  logic [CNTW-1:0] thr;
  logic [CNTW-1:0] char_len;

  assign char_len = par_en ? CNTW'(CHAR_P) : CNTW'(CHAR_NP);
  assign thr      = CNTW'(brk_chars(lvl)) * char_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      active_o <= 1'b0;
      brk_o    <= 1'b0;
    end else begin
      brk_o <= 1'b0;
      if (!en) begin
        low_cnt  <= '0;
        active_o <= 1'b0;
      end else if (tick) begin
        if (rx) begin
          low_cnt  <= '0;
          active_o <= 1'b0;
        end else begin
          if (low_cnt < thr) low_cnt <= low_cnt + 1'b1;
          if ((low_cnt == thr - 1'b1) && !active_o) begin
            brk_o    <= 1'b1;
            active_o <= 1'b1;
          end
        end
      end
    end
  end

  // R8: a break pulse only starts a new break period
  a_r8_break_once: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> (active_o && !$past(active_o)));
  // R9: break status falls only on a high sample or disable
  a_r9_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> ($past(!en) || ($past(tick) && $past(rx))));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R10: a waiting byte stays put until taken or replaced
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));
  // R10: a load always leaves the port valid
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          os_tick,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [1:0]    brk_lvl,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          frame_err,
  output logic          parity_err,
  output logic          break_err,
  output logic          break_active
);
  logic          good;
  logic [DW-1:0] fbyte;

  uart_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rx(rx_in),
    .par_en(par_en), .par_odd(par_odd), .good_o(good), .byte_o(fbyte),
    .ferr_o(frame_err), .perr_o(parity_err)
  );

  uart_rx_break #(.OSR(OSR), .DW(DW)) u_break (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rx(rx_in),
    .par_en(par_en), .lvl(brk_lvl), .brk_o(break_err), .active_o(break_active)
  );

  uart_rx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(good), .load_data(fbyte),
    .ready(rx_ready), .valid(rx_valid), .data(rx_data)
  );

  // R12: no status or byte is presented out of reset
  a_r12_quiet_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rx_valid && !frame_err && !parity_err && !break_err && !break_active));
endmodule

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_in = 1'b1, os_tick = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] brk_lvl = 2'd0;
  logic rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, frame_err, parity_err, break_err, break_active;

  integer total = 0, bad = 0, cyc = 0, div = 0, rdy_mode = 0;
  logic [7:0] lf = 8'h5b;
  integer n_fe = 0, n_pe = 0, n_be = 0, n_good = 0;
  logic [7:0] last_byte = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick), .rx_en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .brk_lvl(brk_lvl), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .frame_err(frame_err),
    .parity_err(parity_err), .break_err(break_err), .break_active(break_active)
  );

  task automatic check(input logic ok, input string req, input integer act, input integer exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // tick and ready generation
  always @(negedge clk) begin
    cyc++;
    div = (div + 1) % TDIV;
    os_tick <= (div == 0);
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (rdy_mode == 0) rx_ready <= 1'b1;
    else if (rdy_mode == 1) rx_ready <= 1'b0;
    else rx_ready <= lf[0];
  end

  // behavioural reference model
  integer m_pos = -1, m_low = 0, thr;
  logic [7:0] m_sh = 0, m_byte = 0, m_data = 0;
  logic m_pbit = 0, m_fe = 0, m_pe = 0, m_good = 0, m_be = 0, m_act = 0, m_valid = 0, pbad;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = -1; m_low = 0; m_act = 0; m_valid = 0;
      m_fe = 0; m_pe = 0; m_good = 0; m_be = 0;
    end else begin
      if (m_good) begin m_valid = 1; m_data = m_byte; end
      else if (m_valid && rx_ready) m_valid = 0;
      m_fe = 0; m_pe = 0; m_good = 0; m_be = 0;
      if (!rx_en) begin
        m_pos = -1; m_low = 0; m_act = 0;
      end else if (os_tick) begin
        thr = (2 << brk_lvl) * 16 * (par_en ? 11 : 10);
        if (rx_in) begin m_low = 0; m_act = 0; end
        else begin
          if (m_low < thr) m_low++;
          if (m_low == thr && !m_act) begin m_be = 1; m_act = 1; end
        end
        if (m_pos < 0) begin
          if (!rx_in) m_pos = 0;
        end else begin
          m_pos++;
          if ((m_pos - 8) % 16 == 0) begin
            if (m_pos == 8) begin
              if (rx_in) m_pos = -1;
            end else if (m_pos <= 8 + 16 * 8) begin
              m_sh[(m_pos - 8) / 16 - 1] = rx_in;
            end else if (par_en && m_pos == 8 + 16 * 9) begin
              m_pbit = rx_in;
            end else begin
              pbad = par_en && (((^m_sh) ^ m_pbit) != par_odd);
              m_fe = !rx_in; m_pe = pbad; m_good = rx_in && !pbad;
              m_byte = m_sh; m_pos = -1;
            end
          end
        end
      end
    end
  end

  // per-clock comparison and event bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      check(frame_err == m_fe, "R5 frame_err", frame_err, m_fe);
      check(parity_err == m_pe, "R4 parity_err", parity_err, m_pe);
      check(break_err == m_be, "R7 break_err", break_err, m_be);
      check(break_active == m_act, "R9 break_active", break_active, m_act);
      check(rx_valid == m_valid, "R3 rx_valid", rx_valid, m_valid);
      if (m_valid) check(rx_data == m_data, "R2 rx_data", rx_data, m_data);
      if (frame_err) n_fe++;
      if (parity_err) n_pe++;
      if (break_err) n_be++;
      if (rx_valid && rx_ready) begin n_good++; last_byte = rx_data; end
    end
  end

  task automatic hold_line(input logic v, input integer clocks);
    rx_in <= v;
    repeat (clocks) @(negedge clk);
  endtask

  // pmode: 0 none, 1 correct parity, 2 wrong parity
  task automatic send(input logic [7:0] b, input integer pmode, input logic stopv);
    logic p;
    p = (^b) ^ par_odd;
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) hold_line(b[i], BITCLK);
    if (pmode == 1) hold_line(p, BITCLK);
    if (pmode == 2) hold_line(!p, BITCLK);
    hold_line(stopv, BITCLK);
    hold_line(1'b1, 3 * BITCLK);
  endtask

  initial begin
    integer base;
    repeat (5) @(negedge clk);
    check(!rx_valid && !frame_err && !parity_err && !break_err && !break_active,
          "R12 reset state", {rx_valid, frame_err, break_active}, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    hold_line(1'b1, 50);

    // R2 R3 plain byte
    send(8'hA5, 0, 1'b1);
    check(last_byte == 8'hA5, "R2 lsb-first byte", last_byte, 8'hA5);
    // R4 even/odd good and bad parity
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C, 1, 1'b1);
    check(last_byte == 8'h3C, "R4 even parity byte", last_byte, 8'h3C);
    par_odd = 1'b1;
    send(8'h71, 1, 1'b1);
    check(last_byte == 8'h71, "R4 odd parity byte", last_byte, 8'h71);
    base = n_pe;
    send(8'h5A, 2, 1'b1);
    check(n_pe == base + 1, "R4 parity mismatch", n_pe, base + 1);
    check(last_byte == 8'h71, "R4 no byte on mismatch", last_byte, 8'h71);
    // R5 stop low
    par_en = 1'b0;
    base = n_fe;
    send(8'h0F, 0, 1'b0);
    check(n_fe == base + 1, "R5 stop low", n_fe, base + 1);
    // R6 ten lows then high
    par_en = 1'b1; par_odd = 1'b0;
    last_byte = 8'hFF;
    base = n_fe;
    hold_line(1'b0, 10 * BITCLK); hold_line(1'b1, 4 * BITCLK);
    check(last_byte == 8'h00 && n_fe == base, "R6 zero byte with parity", last_byte, 0);
    par_en = 1'b0;
    hold_line(1'b0, 10 * BITCLK); hold_line(1'b1, 4 * BITCLK);
    check(n_fe == base + 1, "R6 frame error without parity", n_fe, base + 1);
    // R1 glitch
    base = n_good + n_fe + n_pe;
    hold_line(1'b0, 3 * TDIV); hold_line(1'b1, 12 * BITCLK);
    check(n_good + n_fe + n_pe == base, "R1 glitch rejected", n_good + n_fe + n_pe, base);
    // R10 hold, overwrite, random ready
    rdy_mode = 1;
    send(8'h11, 0, 1'b1);
    send(8'h22, 0, 1'b1);
    check(rx_valid && rx_data == 8'h22, "R10 overwrite waiting byte", rx_data, 8'h22);
    rdy_mode = 2;
    for (int k = 0; k < 6; k++) send(8'h40 + 8'(k * 7), 0, 1'b1);
    rdy_mode = 0;
    // R11 disable mid frame
    base = n_good + n_fe + n_pe;
    hold_line(1'b0, 4 * BITCLK);
    rx_en = 1'b0;
    hold_line(1'b0, 12 * BITCLK);
    hold_line(1'b1, 2 * BITCLK);
    rx_en = 1'b1;
    hold_line(1'b1, 4 * BITCLK);
    check(n_good + n_fe + n_pe == base && !break_active, "R11 disabled is silent",
          n_good + n_fe + n_pe, base);
    // R7 R8 R9 breaks
    par_en = 1'b1; brk_lvl = 2'd0;
    base = n_fe;
    hold_line(1'b0, 3600);
    check(n_be == 1, "R7 break fired", n_be, 1);
    check(n_fe >= base + 4, "R8 frame errors repeat", n_fe, base + 4);
    check(break_active == 1'b1, "R7 break active", break_active, 1);
    hold_line(1'b1, 20 * BITCLK);
    check(break_active == 1'b0, "R9 break released", break_active, 0);
    hold_line(1'b0, 2000);
    check(n_be == 2, "R9 break fires again", n_be, 2);
    hold_line(1'b1, 20 * BITCLK);
    par_en = 1'b0; brk_lvl = 2'd1;
    hold_line(1'b0, 2400);
    check(n_be == 2, "R7 below level 1 threshold", n_be, 2);
    hold_line(1'b0, 600);
    check(n_be == 3, "R7 level 1 threshold", n_be, 3);
    hold_line(1'b1, 20 * BITCLK);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule